// File: doc/BRIEF.md
# Embedded Operation Status Byte Generator

This block builds the byte that a flash-style memory returns on a read while an internal program or erase runs, is suspended, or has failed. A command sequencer supplies the current operation, the bit being written, the set of sectors chosen for erase, the suspend state, whether the erase collection window is still open and a failure pulse. The block turns each read strobe into either a status byte or the array word, one cycle later.

Two toggle bits carry progress. The busy toggle (bit 6) flips on every read while a program or an active erase runs. The erase-sector toggle (bit 2) flips only on reads that fall inside a sector picked for erase. Bit 7 gives complement-data polling, bit 5 is a sticky failure flag and bit 3 shows whether the erase has really begun.

Top module: `status_poll_gen`

## Requirements
- R1: During reset and after reset release with no read, `rd_valid` is 0 and `rd_data` is 0x00.
- R2: A read strobe in cycle N gives `rd_valid`=1 and the new `rd_data` in cycle N+1. With `op_mode`=0 (idle) or 3 (reserved), `rd_data` equals `arr_data` as sampled with the strobe.
- R3: With `op_mode`=1 (program), bit 7 is the inverse of `prog_data[7]`. Bits 4, 3, 2, 1 and 0 read 0.
- R4: Bit 6 holds the busy toggle and reads 0 on the first busy read after reset. The toggle inverts after every read made in program mode or in `op_mode`=2 (erase) without `suspend`.
- R5: In active erase (`op_mode`=2, `suspend`=0), bit 7 reads 0 at any address. Bit 3 reads the inverse of `win_open`.
- R6: Sector index = `rd_addr[ADDR_W-1 -: log2(SECTORS)]`. A sector is selected when its bit in `erase_sel` is 1. Bit 2 holds the erase-sector toggle, which is 0 after reset. It inverts after every erase-mode read of a selected sector, suspended or not. In other reads it keeps its value, and in active erase it is shown unchanged at unselected addresses.
- R7: In suspended erase, a read of a selected sector returns bit 7=1, bit 3=1 and bits 4, 1, 0 = 0, with bit 6 shown unchanged. A read of an unselected sector returns `arr_data`.
- R8: Bit 5 is a failure flag in every status byte. A `fail_in` pulse sets it for reads strobed from the next cycle on. A `fail_clr` pulse clears it, and clear wins when both pulses come together.
- R9: The busy toggle keeps its value across reads in idle, reserved or suspended-erase mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_mode | input | 2 | 0 idle, 1 program, 2 erase, 3 reserved |
| suspend | input | 1 | Erase suspended |
| win_open | input | 1 | Erase sector collection window still open |
| prog_data | input | 8 | Byte being programmed |
| erase_sel | input | SECTORS | One bit per sector chosen for erase |
| fail_in | input | 1 | Pulse: operation exceeded its limit |
| fail_clr | input | 1 | Pulse: reset command seen |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | ADDR_W | Read address |
| arr_data | input | 8 | Array word at the read address |
| rd_data | output | 8 | Returned byte |
| rd_valid | output | 1 | High the cycle after a read strobe |

## Verification
The assertions assume that `rd_stb` is a single-cycle pulse and that `op_mode`, `suspend` and the other qualifiers hold steady while a strobe is sampled. They also assume the sequencer never raises `suspend` outside erase in a way the checks depend on. The bench changes all qualifiers only at falling edges, and only between reads, so each strobe sees one stable context. It mixes random modes, masks, addresses and failure pulses with directed cases for reset, the first toggle value, suspend at selected and unselected sectors, and a clear that coincides with a fail.

// File: rtl/status_poll_pkg.sv
// Package: shared mode encoding and bit positions of the status byte.
// Assumes the sequencer drives op_mode with these codes.
package status_poll_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } op_mode_e;

    localparam int BIT_POLL  = 7;
    localparam int BIT_BUSY  = 6;
    localparam int BIT_FAIL  = 5;
    localparam int BIT_BEGUN = 3;
    localparam int BIT_SECT  = 2;
endpackage

// File: rtl/status_poll_toggle.sv
// Module: one toggle bit that inverts when advanced.
// Assumes adv is high for at most one cycle per read.
module status_poll_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic state
);
    // Invert on each advance, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   state <= 1'b0;
        else if (adv) state <= ~state;
    end
endmodule

// File: rtl/status_poll_sector_hit.sv
// Module: decides whether an address falls in a sector chosen for erase.
// Assumes sectors are equal sized and indexed by the top address bits.
module status_poll_sector_hit #(
    parameter int SECTORS = 8,
    parameter int ADDR_W  = 12
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [SECTORS-1:0] sel,
    output logic               hit
);
    localparam int SEC_W = (SECTORS > 1) ? $clog2(SECTORS) : 1;

    logic [SEC_W-1:0] idx;

    // Pick the sector index from the address and look it up in the mask.
    generate
        if (SECTORS > 1) begin : g_multi
            assign idx = addr[ADDR_W-1 -: SEC_W];
        end else begin : g_single
            assign idx = '0;
        end
    endgenerate

    always_comb hit = sel[idx];
endmodule

// File: rtl/status_poll_gen.sv
// Module: formats the status byte for each read during embedded operations.
// Assumes rd_stb is a one-cycle pulse and qualifiers are stable with it.
module status_poll_gen
    import status_poll_pkg::*;
#(
    parameter int SECTORS = 8,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         op_mode,
    input  logic               suspend,
    input  logic               win_open,
    input  logic [7:0]         prog_data,
    input  logic [SECTORS-1:0] erase_sel,
    input  logic               fail_in,
    input  logic               fail_clr,
    input  logic               rd_stb,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [7:0]         arr_data,
    output logic [7:0]         rd_data,
    output logic               rd_valid
);
    logic     sec_hit;
    logic     busy_tog;
    logic     sect_tog;
    logic     fail_q;
    logic     adv_busy;
    logic     adv_sect;
    logic     use_array;
    logic [7:0] status_b;
    op_mode_e mode;

    assign mode = op_mode_e'(op_mode);

    status_poll_sector_hit #(.SECTORS(SECTORS), .ADDR_W(ADDR_W)) u_hit (
        .addr (rd_addr),
        .sel  (erase_sel),
        .hit  (sec_hit)
    );

    status_poll_toggle u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv_busy),
        .state (busy_tog)
    );

    status_poll_toggle u_sect (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv_sect),
        .state (sect_tog)
    );

    // Decide which toggles move on this read.
    always_comb begin
        adv_busy = rd_stb && ((mode == OP_PROG) || (mode == OP_ERASE && !suspend));
        adv_sect = rd_stb && (mode == OP_ERASE) && sec_hit;
    end

    // Build the status byte and choose between status and array data.
    always_comb begin
        status_b  = 8'h00;
        use_array = 1'b0;
        unique case (mode)
            OP_PROG: begin
                status_b[BIT_POLL] = ~prog_data[7];
                status_b[BIT_BUSY] = busy_tog;
                status_b[BIT_FAIL] = fail_q;
            end
            OP_ERASE: begin
                if (!suspend) begin
                    status_b[BIT_POLL]  = 1'b0;
                    status_b[BIT_BUSY]  = busy_tog;
                    status_b[BIT_FAIL]  = fail_q;
                    status_b[BIT_BEGUN] = ~win_open;
                    status_b[BIT_SECT]  = sect_tog;
                end else if (sec_hit) begin
                    status_b[BIT_POLL]  = 1'b1;
                    status_b[BIT_BUSY]  = busy_tog;
                    status_b[BIT_FAIL]  = fail_q;
                    status_b[BIT_BEGUN] = 1'b1;
                    status_b[BIT_SECT]  = sect_tog;
                end else begin
                    use_array = 1'b1;
                end
            end
            default: use_array = 1'b1;
        endcase
    end

    // Sticky failure flag; a reset command clears it with priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        fail_q <= 1'b0;
        else if (fail_clr) fail_q <= 1'b0;
        else if (fail_in)  fail_q <= 1'b1;
    end

    // Register the returned byte and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= 8'h00;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) rd_data <= use_array ? arr_data : status_b;
        end
    end
endmodule

// File: rtl/status_poll_gen_chk.sv
// Module: assertion checker bound to status_poll_gen.
// Assumes a one-cycle rd_stb and qualifiers stable with it.
module status_poll_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] op_mode,
    input logic       suspend,
    input logic       win_open,
    input logic [7:0] prog_data,
    input logic       fail_in,
    input logic       fail_clr,
    input logic       rd_stb,
    input logic [7:0] rd_data,
    input logic       rd_valid,
    input logic       busy_tog,
    input logic       fail_q
);
    // R2
    valid_follows_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);

    // R3
    prog_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && op_mode == 2'd1) |=>
            (rd_data[7] == ~$past(prog_data[7]) && rd_data[3:0] == 4'h0 && !rd_data[4]));

    // R5
    erase_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && op_mode == 2'd2 && !suspend) |=>
            (!rd_data[7] && rd_data[3] == ~$past(win_open)));

    // R4
    busy_toggles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && op_mode == 2'd1) |=> (busy_tog != $past(busy_tog)));

    // R9
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (op_mode == 2'd0 || op_mode == 2'd3)) |=> $stable(busy_tog));

    // R8
    fail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_in && !fail_clr) |=> fail_q);

    // R8
    fail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_clr |=> !fail_q);
endmodule

bind status_poll_gen status_poll_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_mode   (op_mode),
    .suspend   (suspend),
    .win_open  (win_open),
    .prog_data (prog_data),
    .fail_in   (fail_in),
    .fail_clr  (fail_clr),
    .rd_stb    (rd_stb),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .busy_tog  (busy_tog),
    .fail_q    (fail_q)
);

// File: tb/status_poll_gen_bench.sv
// Bench: random plus directed reads checked against a behavioural model.
module status_poll_gen_bench;
    localparam int SECTORS = 8;
    localparam int ADDR_W  = 12;
    localparam int SEC_W   = $clog2(SECTORS);

    logic               clk = 1'b0;
    logic               rst_n;
    logic [1:0]         op_mode;
    logic               suspend;
    logic               win_open;
    logic [7:0]         prog_data;
    logic [SECTORS-1:0] erase_sel;
    logic               fail_in;
    logic               fail_clr;
    logic               rd_stb;
    logic [ADDR_W-1:0]  rd_addr;
    logic [7:0]         arr_data;
    logic [7:0]         rd_data;
    logic               rd_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // model state
    bit m_busy = 1'b0;
    bit m_sect = 1'b0;
    bit m_fail = 1'b0;

    status_poll_gen #(.SECTORS(SECTORS), .ADDR_W(ADDR_W)) u_status_poll_gen (
        .clk, .rst_n, .op_mode, .suspend, .win_open, .prog_data, .erase_sel,
        .fail_in, .fail_clr, .rd_stb, .rd_addr, .arr_data, .rd_data, .rd_valid
    );

    always #5 clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Expected byte for one read; advances the model toggles.
    function automatic logic [7:0] model_read(logic [ADDR_W-1:0] a);
        logic [7:0] b = 8'h00;
        bit hit = erase_sel[a[ADDR_W-1 -: SEC_W]];
        case (op_mode)
            2'd1: begin
                b[7] = ~prog_data[7]; b[6] = m_busy; b[5] = m_fail;
                m_busy = ~m_busy;
            end
            2'd2: begin
                if (!suspend) begin
                    b[7] = 1'b0; b[6] = m_busy; b[5] = m_fail;
                    b[3] = ~win_open; b[2] = m_sect;
                    m_busy = ~m_busy;
                    if (hit) m_sect = ~m_sect;
                end else if (hit) begin
                    b[7] = 1'b1; b[6] = m_busy; b[5] = m_fail;
                    b[3] = 1'b1; b[2] = m_sect;
                    m_sect = ~m_sect;
                end else begin
                    b = arr_data;
                end
            end
            default: b = arr_data;
        endcase
        return b;
    endfunction

    task automatic do_read(logic [ADDR_W-1:0] a, string req);
        logic [7:0] exp;
        rd_addr = a;
        exp = model_read(a);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check(req, {7'd0, rd_valid}, 8'd1);
        check(req, rd_data, exp);
    endtask

    task automatic pulse_fail(bit set, bit clr);
        fail_in  = set;
        fail_clr = clr;
        @(negedge clk);
        fail_in  = 1'b0;
        fail_clr = 1'b0;
        if (clr) m_fail = 1'b0;
        else if (set) m_fail = 1'b1;
    endtask

    function automatic logic [ADDR_W-1:0] addr_in(int sec);
        return {sec[SEC_W-1:0], ADDR_W'($urandom) & {(ADDR_W-SEC_W){1'b1}}};
    endfunction

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; op_mode = 2'd0; suspend = 1'b0; win_open = 1'b0;
        prog_data = 8'h00; erase_sel = '0; fail_in = 1'b0; fail_clr = 1'b0;
        rd_stb = 1'b0; rd_addr = '0; arr_data = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", rd_data, 8'h00);
        check("R1", {7'd0, rd_valid}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {7'd0, rd_valid}, 8'd0);

        // R2: idle returns array data
        arr_data = 8'hA5; do_read(12'h123, "R2");
        op_mode = 2'd3; arr_data = 8'h3C; do_read(12'h456, "R2");
        // R3/R4: program polling, first toggle 0 then 1
        op_mode = 2'd1; prog_data = 8'h80; do_read(12'h000, "R3_R4");
        prog_data = 8'h7F; do_read(12'hFFF, "R3_R4");
        // R9: idle does not move busy toggle
        op_mode = 2'd0; arr_data = 8'h11; do_read(12'h010, "R9");
        op_mode = 2'd1; do_read(12'h020, "R9");
        // R5/R6: active erase, window open then closed
        op_mode = 2'd2; erase_sel = 8'b0000_0101; win_open = 1'b1;
        do_read(addr_in(0), "R5_R6");
        win_open = 1'b0;
        do_read(addr_in(1), "R5_R6");
        do_read(addr_in(2), "R5_R6");
        // R7: suspended, selected and unselected sectors
        suspend = 1'b1; arr_data = 8'h5A;
        do_read(addr_in(0), "R7");
        do_read(addr_in(0), "R7");
        do_read(addr_in(3), "R7");
        // R8: fail set, then clear with coincident set
        suspend = 1'b0;
        pulse_fail(1'b1, 1'b0);
        do_read(addr_in(2), "R8");
        pulse_fail(1'b1, 1'b1);
        do_read(addr_in(2), "R8");

        // random mix
        for (int i = 0; i < 400; i++) begin
            op_mode   = 2'($urandom_range(0, 3));
            suspend   = ($urandom_range(0, 3) == 0);
            win_open  = $urandom_range(0, 1);
            prog_data = 8'($urandom);
            erase_sel = SECTORS'($urandom);
            arr_data  = 8'($urandom);
            if ($urandom_range(0, 9) == 0)
                pulse_fail($urandom_range(0, 1), $urandom_range(0, 1));
            do_read(ADDR_W'($urandom), "R2_R7_random");
            if ($urandom_range(0, 4) == 0) @(negedge clk);
        end
        finish_run();
    end
endmodule